// File: doc/BRIEF.md
# Minute-Second Countdown Watchdog Register Block

This block is a byte-wide register window of 256 offsets that an embedded controller exposes to a host. Its main content is a watchdog whose remaining time lives in two bytes, one counting minutes and one counting seconds. The two bytes together form a mixed-radix count: seconds run from 59 down to 0, then roll to 59 while minutes drop by one. A prescaler turns the system clock into a one-second tick. While the watchdog is enabled, each tick lowers the count by one second. When the count reaches zero, the block emits a one-cycle reset pulse and switches itself off.

The host loads a timeout by writing the minute and second bytes. It starts the watchdog, or refreshes it as a keepalive, by writing the enable code to the control byte. Every refresh reloads the live count from the last values the host loaded. The host reads time left by fetching minutes, then seconds, then minutes again, and repeats if the two minute values differ. The window also holds a fixed three-byte ASCII signature and a small GPIO pair: a direction byte and a value byte.

Top module: `minsec_wdog_regs`

## Requirements
- R1: A synchronous active-high reset sets the following state: enable off (offset 0x06 reads 0x00), both count bytes 0, GPIO value 0x00, GPIO direction 0xFF (all pins input), and `wdt_rst` low.
- R2: Offset 0x07 holds minutes (0 to 255) and offset 0x08 holds seconds. A write stores the byte in both the live counter and a load copy. A seconds write above 59 is stored as 59. Reads return the live counter.
- R3: The live seconds value never exceeds 59. A tick lowers seconds by one. A tick at seconds 0 with minutes above 0 gives seconds 59 and minutes minus one.
- R4: While enabled, a tick occurs on the clock edge that closes every TICK_DIV-th cycle, counted from the edge that wrote the enable code. While disabled, no tick occurs.
- R5: Writing 0x01 to offset 0x06 sets the enable and reloads the live count from the load copy. This write is the keepalive. Bit 0 of offset 0x06 reads back the enable.
- R6: Writing 0x00 to offset 0x06 clears the enable and freezes the count. Other values written to 0x06 change nothing. A tick that falls on a cycle with a host write to 0x06, 0x07 or 0x08 is discarded.
- R7: When an enabled tick brings the count to 0:00, or finds it already at 0:00, `wdt_rst` goes high for exactly the one following cycle and the enable clears.
- R8: Offsets 0x4D, 0x4E and 0x4F read 0x50, 0x57 and 0x47. Every offset not named in R2, R5 or R9 reads 0x00, and writes to it are ignored.
- R9: Offset 0x2B is the direction byte, with 1 meaning input. It drives `gpio_dir`. Offset 0x2C is the value byte and drives `gpio_out`. A read of 0x2C returns `gpio_in` for input bits and the stored value for output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 8 | Byte offset within the window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| gpio_in | input | 8 | Pin levels seen by the block |
| gpio_out | output | 8 | Stored GPIO value byte |
| gpio_dir | output | 8 | Direction byte, 1 = input |
| wdt_rst | output | 1 | One-cycle reset pulse on expiry |

## Verification
The countdown is exercised with four kinds of load:
- A plain seconds-only load separates a correct tick spacing from an off-by-one prescaler.
- A load of 1:00 tells a proper base-60 borrow from a binary wrap to 255.
- A mid-count refresh shows whether the reload comes from the load copy or from the live counters.
- A load that runs to zero tells a single-cycle pulse from a held or missing one.

Loads of 0:00 and of out-of-range seconds, together with writes of stray control values, probe the boundaries. A behavioural model checks every readable byte and every output on each cycle, which catches ticks that should have been discarded when they coincide with host writes.

// File: rtl/wdreg_pkg.sv
package wdreg_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] OFS_CTRL = 8'h06;
    localparam logic [7:0] OFS_MIN  = 8'h07;
    localparam logic [7:0] OFS_SEC  = 8'h08;
    localparam logic [7:0] OFS_GDIR = 8'h2B;
    localparam logic [7:0] OFS_GVAL = 8'h2C;
    localparam logic [7:0] OFS_SIG0 = 8'h4D;
    localparam logic [7:0] OFS_SIG1 = 8'h4E;
    localparam logic [7:0] OFS_SIG2 = 8'h4F;

    localparam logic [7:0] CTRL_ON  = 8'h01;
    localparam logic [7:0] CTRL_OFF = 8'h00;
    localparam logic [7:0] SEC_TOP  = 8'd59;

    localparam logic [7:0] SIG_B0 = 8'h50;
    localparam logic [7:0] SIG_B1 = 8'h57;
    localparam logic [7:0] SIG_B2 = 8'h47;

    typedef struct packed {
        logic [BYTE_W-1:0] mins;
        logic [BYTE_W-1:0] secs;
    } mmss_t;

    typedef struct packed {
        logic ctrl;
        logic mins;
        logic secs;
        logic gdir;
        logic gval;
    } wsel_t;

    function automatic logic mmss_zero(mmss_t c);
        return (c.mins == '0) && (c.secs == '0);
    endfunction

    function automatic mmss_t mmss_dec(mmss_t c);
        mmss_t n;
        n = c;
        if (c.secs != '0) begin
            n.secs = c.secs - 8'd1;
        end else if (c.mins != '0) begin
            n.mins = c.mins - 8'd1;
            n.secs = SEC_TOP;
        end
        return n;
    endfunction

    function automatic logic [7:0] clamp_sec(logic [7:0] v);
        return (v > SEC_TOP) ? SEC_TOP : v;
    endfunction

endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int unsigned TICK_DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned CW = $clog2((TICK_DIV > 1) ? TICK_DIV : 2);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o); // R4
        end
    endgenerate

endmodule

// File: rtl/wd_countdown.sv
module wd_countdown
    import wdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wsel_t       wsel_i,
    input  logic [7:0]  wdata_i,
    input  logic        tick_i,
    output logic        en_o,
    output mmss_t       live_o,
    output logic        restart_o,
    output logic        expire_o
);
    mmss_t live_q, load_q, next_c;
    logic  en_q, pulse_q, host_any;

    assign host_any  = wsel_i.ctrl || wsel_i.mins || wsel_i.secs;
    assign restart_o = wsel_i.ctrl && (wdata_i == CTRL_ON);
    assign next_c    = mmss_dec(live_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '0;
            load_q  <= '0;
            en_q    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (host_any) begin
                if (wsel_i.mins) begin
                    live_q.mins <= wdata_i;
                    load_q.mins <= wdata_i;
                end
                if (wsel_i.secs) begin
                    live_q.secs <= clamp_sec(wdata_i);
                    load_q.secs <= clamp_sec(wdata_i);
                end
                if (restart_o) begin
                    en_q   <= 1'b1;
                    live_q <= load_q;
                end else if (wsel_i.ctrl && (wdata_i == CTRL_OFF)) begin
                    en_q <= 1'b0;
                end
            end else if (tick_i && en_q) begin
                live_q <= next_c;
                if (mmss_zero(next_c)) begin
                    pulse_q <= 1'b1;
                    en_q    <= 1'b0;
                end
            end
        end
    end

    assign en_o     = en_q;
    assign live_o   = live_q;
    assign expire_o = pulse_q;

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        live_q.secs <= SEC_TOP); // R3
    AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !host_any) |=> $stable(live_q)); // R4
    AST_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        (tick_i && en_q && !host_any && live_q.secs == 8'd0 && live_q.mins != 8'd0)
        |=> (live_q.secs == SEC_TOP && live_q.mins == $past(live_q.mins) - 8'd1)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q); // R7
    AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> !en_q); // R7
    AST_REFRESH_RELOAD: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> (en_q && live_q == $past(load_q))); // R5

endmodule

// File: rtl/wd_gpio_regs.sv
module wd_gpio_regs
    import wdreg_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_dir_i,
    input  logic            wr_val_i,
    input  logic [NPIN-1:0] wdata_i,
    input  logic [NPIN-1:0] pins_i,
    output logic [NPIN-1:0] dir_o,
    output logic [NPIN-1:0] val_o,
    output logic [NPIN-1:0] rd_val_o
);
    logic [NPIN-1:0] dir_q, val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            val_q <= '0;
        end else begin
            if (wr_dir_i) dir_q <= wdata_i;
            if (wr_val_i) val_q <= wdata_i;
        end
    end

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_pin
            assign rd_val_o[i] = dir_q[i] ? pins_i[i] : val_q[i];
        end
    endgenerate

    assign dir_o = dir_q;
    assign val_o = val_q;

    AST_GPIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_dir_i && !wr_val_i) |=> ($stable(dir_q) && $stable(val_q))); // R9

endmodule

// File: rtl/minsec_wdog_regs.sv
module minsec_wdog_regs
    import wdreg_pkg::*;
#(
    parameter int unsigned TICK_DIV = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_we,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [7:0] gpio_in,
    output logic [7:0] gpio_out,
    output logic [7:0] gpio_dir,
    output logic       wdt_rst
);
    wsel_t      wsel;
    logic       tick, en, restart;
    mmss_t      live;
    logic [7:0] gval_rd;

    always_comb begin
        wsel      = '0;
        wsel.ctrl = host_we && (host_addr == OFS_CTRL);
        wsel.mins = host_we && (host_addr == OFS_MIN);
        wsel.secs = host_we && (host_addr == OFS_SEC);
        wsel.gdir = host_we && (host_addr == OFS_GDIR);
        wsel.gval = host_we && (host_addr == OFS_GVAL);
    end

    wd_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run_i     (en),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wd_countdown u_count (
        .clk       (clk),
        .rst       (rst),
        .wsel_i    (wsel),
        .wdata_i   (host_wdata),
        .tick_i    (tick),
        .en_o      (en),
        .live_o    (live),
        .restart_o (restart),
        .expire_o  (wdt_rst)
    );

    wd_gpio_regs #(.NPIN(8)) u_gpio (
        .clk      (clk),
        .rst      (rst),
        .wr_dir_i (wsel.gdir),
        .wr_val_i (wsel.gval),
        .wdata_i  (host_wdata),
        .pins_i   (gpio_in),
        .dir_o    (gpio_dir),
        .val_o    (gpio_out),
        .rd_val_o (gval_rd)
    );

    always_comb begin
        unique case (host_addr)
            OFS_CTRL: host_rdata = {7'd0, en};
            OFS_MIN:  host_rdata = live.mins;
            OFS_SEC:  host_rdata = live.secs;
            OFS_GDIR: host_rdata = gpio_dir;
            OFS_GVAL: host_rdata = gval_rd;
            OFS_SIG0: host_rdata = SIG_B0;
            OFS_SIG1: host_rdata = SIG_B1;
            OFS_SIG2: host_rdata = SIG_B2;
            default:  host_rdata = 8'h00;
        endcase
    end

    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (live.mins == 8'd0 && live.secs == 8'd0)); // R7
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!en && !host_we) |=> $stable(live)); // R6

endmodule

// File: tb/tb_minsec_wdog_regs.sv
module tb_minsec_wdog_regs;
    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] gpio_in = 8'h00;
    logic [7:0] gpio_out, gpio_dir;
    logic       wdt_rst;

    int n_checks = 0;
    int n_fails  = 0;
    bit live_cmp = 1'b0;

    always #5 clk = ~clk;

    minsec_wdog_regs #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_dir(gpio_dir), .wdt_rst(wdt_rst)
    );

    // behavioural reference model
    int m_en, m_min, m_sec, m_lmin, m_lsec, m_pc, m_pulse, m_dir, m_val;

    always @(posedge clk) begin
        int tk, hw, s;
        tk = (m_en != 0) && (m_pc == DIV - 1);
        if (rst) begin
            m_en = 0; m_min = 0; m_sec = 0; m_lmin = 0; m_lsec = 0;
            m_pc = 0; m_pulse = 0; m_dir = 255; m_val = 0;
        end else begin
            if (m_en == 0 || (host_we && host_addr == 8'h06 && host_wdata == 8'h01)) m_pc = 0;
            else m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
            m_pulse = 0;
            hw = host_we && (host_addr == 8'h06 || host_addr == 8'h07 || host_addr == 8'h08);
            if (host_we && host_addr == 8'h07) begin m_min = host_wdata; m_lmin = host_wdata; end
            if (host_we && host_addr == 8'h08) begin
                s = (host_wdata > 59) ? 59 : host_wdata;
                m_sec = s; m_lsec = s;
            end
            if (host_we && host_addr == 8'h06 && host_wdata == 8'h01) begin
                m_en = 1; m_min = m_lmin; m_sec = m_lsec;
            end
            if (host_we && host_addr == 8'h06 && host_wdata == 8'h00) m_en = 0;
            if (host_we && host_addr == 8'h2B) m_dir = host_wdata;
            if (host_we && host_addr == 8'h2C) m_val = host_wdata;
            if (!hw && tk) begin
                if (m_min * 60 + m_sec > 0) begin
                    if (m_sec > 0) m_sec = m_sec - 1;
                    else begin m_min = m_min - 1; m_sec = 59; end
                end
                if (m_min * 60 + m_sec == 0) begin m_pulse = 1; m_en = 0; end
            end
        end
    end

    function automatic int model_read(logic [7:0] a);
        case (a)
            8'h06: return m_en;
            8'h07: return m_min;
            8'h08: return m_sec;
            8'h2B: return m_dir;
            8'h2C: return (m_dir & gpio_in) | (~m_dir & m_val & 255);
            8'h4D: return 8'h50;
            8'h4E: return 8'h57;
            8'h4F: return 8'h47;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h06: return "R5";
            8'h07: return "R2";
            8'h08: return "R3";
            8'h2B, 8'h2C: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live_cmp) begin
            check("R7", int'(wdt_rst), m_pulse);
            check("R9", int'(gpio_out), m_val);
            check("R9", int'(gpio_dir), m_dir);
            check(tag_of(host_addr), int'(host_rdata), model_read(host_addr));
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(posedge clk); #2;
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(posedge clk); #2;
        host_we = 1'b0;
    endtask

    task automatic rd_check(logic [7:0] a, int exp, string tag);
        #1;
        host_addr = a;
        @(negedge clk);
        check(tag, int'(host_rdata), exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        int pulses;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        live_cmp = 1'b1;
        // R1 reset state
        rd_check(8'h06, 0, "R1");
        rd_check(8'h07, 0, "R1");
        rd_check(8'h08, 0, "R1");
        check("R1", int'(gpio_dir), 8'hFF);
        check("R1", int'(gpio_out), 8'h00);
        check("R1", int'(wdt_rst), 0);

        // R2 full-scale minutes, clamped seconds
        wr(8'h07, 8'hFF); rd_check(8'h07, 255, "R2");
        wr(8'h08, 8'd75); rd_check(8'h08, 59, "R2");

        // R4 tick spacing: 0:10, three periods -> 0:07
        wr(8'h07, 8'd0); wr(8'h08, 8'd10); wr(8'h06, 8'h01);
        repeat (3 * DIV) @(posedge clk); #2;
        rd_check(8'h08, 7, "R4");
        wr(8'h06, 8'h00);

        // R3 base-60 borrow from 1:00
        wr(8'h07, 8'd1); wr(8'h08, 8'd0); wr(8'h06, 8'h01);
        repeat (DIV) @(posedge clk); #2;
        rd_check(8'h08, 59, "R3");
        rd_check(8'h07, 0, "R3");
        wr(8'h06, 8'h00);

        // R6 stop freezes count, stray control value ignored
        wr(8'h07, 8'd0); wr(8'h08, 8'd20); wr(8'h06, 8'h01);
        repeat (DIV) @(posedge clk); #2;
        wr(8'h06, 8'h00);
        repeat (3 * DIV) @(posedge clk); #2;
        rd_check(8'h08, 19, "R6");
        wr(8'h06, 8'h05);
        rd_check(8'h06, 0, "R6");

        // R5 keepalive reloads loaded value
        wr(8'h08, 8'd4); wr(8'h06, 8'h01);
        repeat (2 * DIV) @(posedge clk); #2;
        rd_check(8'h08, 2, "R5");
        wr(8'h06, 8'h01);
        rd_check(8'h08, 4, "R5");
        rd_check(8'h06, 1, "R5");

        // R7 expiry pulse
        wr(8'h08, 8'd2); wr(8'h06, 8'h01);
        pulses = 0;
        repeat (4 * DIV) begin @(negedge clk); if (wdt_rst) pulses++; end
        check("R7", pulses, 1);
        rd_check(8'h06, 0, "R7");
        rd_check(8'h08, 0, "R7");

        // R7 enable with 0:00 loaded fires on first tick
        wr(8'h08, 8'd0); wr(8'h06, 8'h01);
        pulses = 0;
        repeat (3 * DIV) begin @(negedge clk); if (wdt_rst) pulses++; end
        check("R7", pulses, 1);

        // R8 signature and unmapped offsets
        rd_check(8'h4D, 8'h50, "R8");
        rd_check(8'h4E, 8'h57, "R8");
        rd_check(8'h4F, 8'h47, "R8");
        wr(8'h10, 8'hAA);
        rd_check(8'h10, 0, "R8");
        rd_check(8'h06, 0, "R8");

        // R9 GPIO direction and value mix
        gpio_in = 8'h3C;
        wr(8'h2B, 8'h0F); wr(8'h2C, 8'hA5);
        rd_check(8'h2C, 8'hAC, "R9");
        check("R9", int'(gpio_dir), 8'h0F);
        check("R9", int'(gpio_out), 8'hA5);
        gpio_in = 8'hC3;
        rd_check(8'h2C, 8'hA3, "R9");

        // R1 reset again after activity
        wr(8'h07, 8'd3); wr(8'h08, 8'd9); wr(8'h06, 8'h01);
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        rd_check(8'h07, 0, "R1");
        rd_check(8'h06, 0, "R1");
        check("R1", int'(gpio_dir), 8'hFF);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule